// File: doc/BRIEF.md
# File Register Operate and Skip Unit

This unit is the execute slice of an 8-bit accumulator-style core that handles a handful of single-operand instructions working on the register file. Each cycle it may accept one decoded instruction: an operation code, the 7-bit address of the register involved, a destination select, a 3-bit bit index and the operand value already read from the register file. One clock later it presents the result, the address it belongs to, and at most one write enable: either toward the working register or toward the addressed file register. Alongside these it presents a zero-flag update and a skip request toward instruction fetch.

Complement and decrement send their result wherever the destination select points, and both set the zero flag from that result. The two clear operations produce zero and force the zero flag to one. The bit test writes nothing and leaves the flags alone. When the tested bit is clear, it raises a one-cycle skip request so that fetch turns the next instruction into a no-op. The unit also drops the instruction it receives in the slot right after a skip, so the squashed slot has no effect even if it still reaches this stage. A skipping test therefore costs two cycles.

Top module: `fru_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all write enables, the zero update and the skip request are 0 after that edge, and `out_data` is 00h.
- R2: Operation code 1 (complement) produces the bitwise inverse of the operand one cycle later. Destination 0 raises only `out_wreg_we`. Destination 1 raises only `out_freg_we`. The two write enables are never high together.
- R3: Operation code 2 (decrement) produces operand minus one modulo 256, so 00h gives FFh. It is steered by the destination bit in the same way as R2.
- R4: Complement and decrement raise `out_zero_we`, with `out_zero` equal to 1 exactly when the 8-bit result is 00h.
- R5: Operation code 3 (clear register) produces 00h with `out_freg_we`, `out_zero_we` and `out_zero` all 1, whatever the destination bit and operand.
- R6: Operation code 4 (clear working register) produces 00h with `out_wreg_we`, `out_zero_we` and `out_zero` all 1.
- R7: Operation code 5 (bit test) raises no write enable and no zero update. `out_skip` is 1 exactly when operand bit `in_bit` (bit 0 = LSB) is 0.
- R8: `out_skip` is high for one cycle only. An instruction presented in the cycle that `out_skip` is high is squashed: it causes no write, no zero update and no skip.
- R9: With `in_valid` low, or with operation codes 0, 6 or 7, no write, zero update or skip results.
- R10: `out_addr` carries the `in_addr` of the instruction whose result is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Operation code (1 complement, 2 decrement, 3 clear register, 4 clear working register, 5 bit test) |
| in_addr | input | 7 | Register address |
| in_dest | input | 1 | 0 = working register, 1 = addressed register |
| in_bit | input | 3 | Bit index for the test |
| in_operand | input | 8 | Value read from the addressed register |
| out_data | output | 8 | Result value |
| out_addr | output | 7 | Address belonging to the result |
| out_wreg_we | output | 1 | Write result to working register |
| out_freg_we | output | 1 | Write result to addressed register |
| out_zero_we | output | 1 | Update the zero flag |
| out_zero | output | 1 | New zero flag value |
| out_skip | output | 1 | Squash the next fetched instruction |

## Verification
The properties assume that `in_op` holds a defined code whenever `in_valid` is high. They also assume that reset is held for at least one edge before activity starts, since the reset property looks one edge ahead. The bench drives every field from a task that changes inputs only on the falling edge and always uses complete values, so no unknowns reach the unit. Its stimulus includes undefined operation codes and idle slots only in the forms R9 covers. It also places instructions directly behind a skipping test on purpose, to exercise the squash window.

// File: rtl/fru_pkg.sv
// Shared definitions for the file register operate and skip unit.
// Assumes the decoder delivers one of these codes on in_op.
package fru_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_COMP = 3'd1,
        OP_DECR = 3'd2,
        OP_CLRF = 3'd3,
        OP_CLRW = 3'd4,
        OP_BTSC = 3'd5
    } fru_op_e;
endpackage

// File: rtl/fru_operate.sv
// Arithmetic core: computes the result value and the zero flag value
// for the operating instructions. Purely combinational; assumes op is
// already qualified elsewhere (no gating by valid here).
module fru_operate #(
    parameter int DATA_W = 8
) (
    input  fru_pkg::fru_op_e    op,
    input  logic [DATA_W-1:0]   operand,
    output logic [DATA_W-1:0]   result,
    output logic                zero_val
);
    import fru_pkg::*;

    // Select the result value by operation.
    always_comb begin
        unique case (op)
            OP_COMP: result = ~operand;
            OP_DECR: result = operand - DATA_W'(1);
            default: result = '0;
        endcase
    end

    // Clears force the flag; the others derive it from their result.
    always_comb begin
        if (op == OP_CLRF || op == OP_CLRW) zero_val = 1'b1;
        else                                zero_val = ~|result;
    end
endmodule

// File: rtl/fru_bit_probe.sv
// Bit test helper: reports whether the selected operand bit is clear.
// Built as a one-hot decode of the index so that each lane is a
// two-input gate; assumes sel < DATA_W.
module fru_bit_probe #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_clear
);
    logic [DATA_W-1:0] hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        // Lane i fires when it is selected and its bit is zero.
        assign hit[i] = (sel == SEL_W'(i)) & ~operand[i];
    end

    assign bit_clear = |hit;
endmodule

// File: rtl/fru_steer.sv
// Destination steering: turns the qualified operation and destination
// bit into write enables, the zero update enable and the skip request.
// Assumes squash is the registered skip of the previous slot.
module fru_steer (
    input  logic             valid,
    input  logic             squash,
    input  fru_pkg::fru_op_e op,
    input  logic             dest,
    input  logic             bit_clear,
    output logic             wreg_we,
    output logic             freg_we,
    output logic             zero_we,
    output logic             skip
);
    import fru_pkg::*;

    logic take;
    logic is_arith;

    // An instruction counts only if present and not in a squashed slot.
    always_comb begin
        take     = valid & ~squash;
        is_arith = (op == OP_COMP) | (op == OP_DECR);
    end

    // Route the effect of the accepted instruction.
    always_comb begin
        wreg_we = take & ((is_arith & ~dest) | (op == OP_CLRW));
        freg_we = take & ((is_arith &  dest) | (op == OP_CLRF));
        zero_we = take & (is_arith | (op == OP_CLRF) | (op == OP_CLRW));
        skip    = take & (op == OP_BTSC) & bit_clear;
    end
endmodule

// File: rtl/fru_unit.sv
// File register operate and skip unit (top). Registers the result of
// one decoded instruction per cycle: value, address, destination
// enables, zero update and a one-cycle skip request. The slot after a
// skip is dropped locally. Assumes operand was read for in_addr.
module fru_unit #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_dest,
    input  logic [SEL_W-1:0]  in_bit,
    input  logic [DATA_W-1:0] in_operand,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_wreg_we,
    output logic              out_freg_we,
    output logic              out_zero_we,
    output logic              out_zero,
    output logic              out_skip
);
    import fru_pkg::*;

    fru_op_e           op;
    logic [DATA_W-1:0] result;
    logic              zero_val;
    logic              bit_clear;
    logic              wreg_we_d;
    logic              freg_we_d;
    logic              zero_we_d;
    logic              skip_d;

    assign op = fru_op_e'(in_op);

    fru_operate #(.DATA_W(DATA_W)) operate_i (
        .op       (op),
        .operand  (in_operand),
        .result   (result),
        .zero_val (zero_val)
    );

    fru_bit_probe #(.DATA_W(DATA_W)) probe_i (
        .operand   (in_operand),
        .sel       (in_bit),
        .bit_clear (bit_clear)
    );

    fru_steer steer_i (
        .valid     (in_valid),
        .squash    (out_skip),
        .op        (op),
        .dest      (in_dest),
        .bit_clear (bit_clear),
        .wreg_we   (wreg_we_d),
        .freg_we   (freg_we_d),
        .zero_we   (zero_we_d),
        .skip      (skip_d)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_addr    <= '0;
            out_wreg_we <= 1'b0;
            out_freg_we <= 1'b0;
            out_zero_we <= 1'b0;
            out_zero    <= 1'b0;
            out_skip    <= 1'b0;
        end else begin
            out_data    <= result;
            out_addr    <= in_addr;
            out_wreg_we <= wreg_we_d;
            out_freg_we <= freg_we_d;
            out_zero_we <= zero_we_d;
            out_zero    <= zero_val;
            out_skip    <= skip_d;
        end
    end
endmodule

// File: rtl/fru_unit_chk.sv
// Property checker for fru_unit, attached by bind. Observes ports only.
module fru_unit_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [ADDR_W-1:0] in_addr,
    input logic              in_dest,
    input logic [SEL_W-1:0]  in_bit,
    input logic [DATA_W-1:0] in_operand,
    input logic [DATA_W-1:0] out_data,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_wreg_we,
    input logic              out_freg_we,
    input logic              out_zero_we,
    input logic              out_zero,
    input logic              out_skip
);
    // R1: reset leaves the outputs quiet.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_wreg_we && !out_freg_we && !out_zero_we
                    && !out_skip && out_data == '0));

    // R2: never both destinations at once.
    p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_wreg_we, out_freg_we}));

    // R3: decrement of zero wraps to all ones.
    p_decr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd2 && !out_skip && in_operand == '0)
        |=> (out_data == '1 && !out_zero));

    // R4: an updated zero flag agrees with the result.
    p_zero_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_zero_we |-> (out_zero == (out_data == '0)));

    // R5: clear register writes zero to the file and sets the flag.
    p_clr_file_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd3 && !out_skip)
        |=> (out_freg_we && !out_wreg_we && out_zero && out_data == '0));

    // R6: clear working register writes zero to W and sets the flag.
    p_clr_w_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd4 && !out_skip)
        |=> (out_wreg_we && !out_freg_we && out_zero && out_data == '0));

    // R7: bit test touches no register and no flag.
    p_btsc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd5)
        |=> (!out_wreg_we && !out_freg_we && !out_zero_we));

    // R8: skip lasts one cycle and the next slot has no effect.
    p_skip_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_skip |=> (!out_skip && !out_wreg_we && !out_freg_we && !out_zero_we));

    // R9: an empty slot has no effect.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_skip && !out_wreg_we && !out_freg_we && !out_zero_we));

    // R10: the address follows its instruction.
    p_addr_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_addr == $past(in_addr)));
endmodule

bind fru_unit fru_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_addr(in_addr), .in_dest(in_dest), .in_bit(in_bit),
    .in_operand(in_operand), .out_data(out_data), .out_addr(out_addr),
    .out_wreg_we(out_wreg_we), .out_freg_we(out_freg_we),
    .out_zero_we(out_zero_we), .out_zero(out_zero), .out_skip(out_skip)
);

// File: tb/fru_unit_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected items, the monitor pops
// and compares them on the falling edge once they are due.
module fru_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = 3'd0;
    logic [6:0] in_addr = 7'd0;
    logic       in_dest = 1'b0;
    logic [2:0] in_bit = 3'd0;
    logic [7:0] in_operand = 8'd0;
    logic [7:0] out_data;
    logic [6:0] out_addr;
    logic       out_wreg_we, out_freg_we, out_zero_we, out_zero, out_skip;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit model_skip = 1'b0;

    typedef struct {
        int        due;
        bit        wwe, fwe, zwe, zval, skip;
        logic [7:0] data;
        logic [6:0] addr;
        string     tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;   // 200 MHz

    fru_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_addr(in_addr), .in_dest(in_dest), .in_bit(in_bit),
        .in_operand(in_operand), .out_data(out_data), .out_addr(out_addr),
        .out_wreg_we(out_wreg_we), .out_freg_we(out_freg_we),
        .out_zero_we(out_zero_we), .out_zero(out_zero), .out_skip(out_skip)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: apply one slot and push what the requirements predict.
    task automatic drive(input bit v, input logic [2:0] op, input logic [6:0] a,
                         input bit d, input logic [2:0] b, input logic [7:0] x,
                         input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v; in_op = op; in_addr = a; in_dest = d; in_bit = b; in_operand = x;
        e = '{due: cyc + 1, wwe: 0, fwe: 0, zwe: 0, zval: 0, skip: 0,
              data: 8'h00, addr: a, tag: tag};
        if (v && !model_skip) begin
            case (op)
                3'd1: begin e.data = ~x;        e.wwe = !d; e.fwe = d; e.zwe = 1; end
                3'd2: begin e.data = x - 8'd1;  e.wwe = !d; e.fwe = d; e.zwe = 1; end
                3'd3: begin e.data = 8'h00; e.fwe = 1; e.zwe = 1; end
                3'd4: begin e.data = 8'h00; e.wwe = 1; e.zwe = 1; end
                3'd5: e.skip = !x[b];
                default: ;
            endcase
        end
        e.zval = (e.data == 8'h00);
        model_skip = e.skip;
        sb.push_back(e);
    endtask

    // Monitor: compare every due item against the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            bad = (out_wreg_we != e.wwe) || (out_freg_we != e.fwe) ||
                  (out_zero_we != e.zwe) || (out_skip != e.skip) ||
                  (out_addr != e.addr) ||
                  ((e.wwe || e.fwe) && out_data != e.data) ||
                  (e.zwe && out_zero != e.zval);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: got w=%0b f=%0b zwe=%0b z=%0b skip=%0b data=%h addr=%h, expected w=%0b f=%0b zwe=%0b z=%0b skip=%0b data=%h addr=%h",
                         e.tag, out_wreg_we, out_freg_we, out_zero_we, out_zero, out_skip,
                         out_data, out_addr, e.wwe, e.fwe, e.zwe, e.zval, e.skip, e.data, e.addr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds outputs quiet despite a live complement input.
        in_valid = 1'b1; in_op = 3'd1; in_operand = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_wreg_we || out_freg_we || out_zero_we || out_skip || out_data != 8'h00) begin
            errors++;
            $display("FAIL R1: got w=%0b f=%0b zwe=%0b skip=%0b data=%h, expected all 0",
                     out_wreg_we, out_freg_we, out_zero_we, out_skip, out_data);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        drive(1, 3'd1, 7'h10, 0, 0, 8'h5A, "R2 comp to W");
        drive(1, 3'd1, 7'h11, 1, 0, 8'hFF, "R2/R4 comp to F zero");
        drive(1, 3'd2, 7'h12, 0, 0, 8'h01, "R3/R4 decr to W zero");
        drive(1, 3'd2, 7'h13, 1, 0, 8'h00, "R3 decr wrap");
        drive(1, 3'd2, 7'h7F, 1, 0, 8'h80, "R3/R10 decr top address");
        drive(1, 3'd3, 7'h20, 0, 0, 8'h33, "R5 clear reg ignores dest");
        drive(1, 3'd3, 7'h21, 1, 0, 8'hC3, "R5 clear reg");
        drive(1, 3'd4, 7'h22, 1, 0, 8'h99, "R6 clear W");
        drive(1, 3'd5, 7'h30, 0, 3, 8'h08, "R7 test set no skip");
        drive(1, 3'd5, 7'h31, 0, 3, 8'hF7, "R7 test clear skip");
        drive(1, 3'd1, 7'h32, 1, 0, 8'h0F, "R8 squashed comp");
        drive(1, 3'd1, 7'h33, 1, 0, 8'h0F, "R8 slot after squash runs");
        drive(1, 3'd5, 7'h34, 0, 0, 8'h00, "R7 skip back to back a");
        drive(1, 3'd5, 7'h35, 0, 1, 8'h00, "R8 second test squashed");
        drive(1, 3'd4, 7'h36, 0, 0, 8'h00, "R6 after squash");
        for (int i = 0; i < 8; i++) begin
            drive(1, 3'd5, 7'(i), 0, 3'(i), 8'(1 << i), "R7 walking one set");
            drive(1, 3'd5, 7'(i), 0, 3'(i), ~8'(1 << i), "R7 walking zero skip");
            drive(0, 3'd1, 7'h00, 0, 0, 8'h00, "R8/R9 idle after skip");
        end
        drive(1, 3'd6, 7'h40, 1, 0, 8'h12, "R9 code 6");
        drive(1, 3'd7, 7'h41, 0, 0, 8'h00, "R9 code 7");
        drive(1, 3'd0, 7'h42, 1, 0, 8'h34, "R9 code 0");
        drive(0, 3'd3, 7'h43, 1, 0, 8'h34, "R9 valid low clear");
        drive(1, 3'd1, 7'h44, 0, 0, 8'h00, "R2/R4 comp nonzero");
        drive(1, 3'd2, 7'h45, 0, 0, 8'h10, "R3/R4 decr nonzero");
        drive(0, 3'd0, 7'h00, 0, 0, 8'h00, "R9 flush");
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10: got %0d pending items, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule